// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a page table entry by walking a directory and a table held in ordinary memory. A caller pulses `start` with the address, the access kind, the current privilege level, the directory base and the write-protect enable. The walker then issues single-word reads and writes on a request/acknowledge memory port. When the result is ready it raises `done` for one cycle with the final entry, the physical address, a fault flag and a three-bit error code.

During the walk the block keeps the in-memory bookkeeping bits up to date. It sets the accessed bit of each level and the dirty bit of the table entry on writes. It returns an entry whose writable and user bits are narrowed by the directory entry.

A direct-mapped translation cache sits in front of the walk. It is indexed by the low bits of the virtual page number and tagged by the rest. A hit answers without touching memory. A `flush` input empties it.

Entry bit positions used throughout: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, frame = bits 31:12. The linear address splits into directory index 31:22, table index 21:12 and offset 11:0.

Top module: `xlat_walker`

## Requirements
- R1: The directory entry is read from `dir_base + 4*lin_addr[31:22]`. The table entry is read from `{directory_entry[31:12], 12'h000} + 4*lin_addr[21:12]`. `phys_addr` is `{entry[31:12], lin_addr[11:0]}`.
- R2: If the directory entry or the table entry has bit 0 clear, the walk ends with `entry` = 0 and `fault` = 1. No table read follows an absent directory entry.
- R3: A present directory entry with bit 5 clear is written back to the same address with bit 5 set, before the table entry is read.
- R4: A present table entry is written back with bit 5 set, and also bit 6 set on a write access, whenever that changes it. The returned entry carries these bits. No write-back occurs when nothing changes.
- R5: The returned bit 1 is the AND of the directory and table bit 1. The returned bit 2 is the AND of the two bit-2 values.
- R6: A translation that completed a two-level walk is cached. A later access to the same page returns the same entry with no memory transaction.
- R7: A one-cycle `flush` pulse invalidates every cache entry, so the next access to a cached page walks memory again.
- R8: `fault` is raised when the returned entry has bit 2 clear and `priv` is nonzero.
- R9: A write access faults when `wp_en` = 1 and the returned bit 1 is clear. With `wp_en` = 0 it does not fault for that reason.
- R10: `fault_code` bit 0 = returned present bit, bit 1 = 1 for a write access, bit 2 = 1 when `priv` is nonzero.
- R11: At most one memory request is open. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. `done` is a one-cycle pulse, and `fault` is only high with `done`.
- R12: After reset `done`, `fault` and `mem_req` are low and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| start | input | 1 | Begin a translation (idle only) |
| lin_addr | input | 32 | Linear address to translate |
| is_write | input | 1 | 1 = write access, 0 = read |
| priv | input | 2 | Current privilege level |
| dir_base | input | 32 | Physical base of the page directory |
| wp_en | input | 1 | Write-protect enable |
| mem_req | output | 1 | Memory request open |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Result valid (one cycle) |
| entry | output | 32 | Resulting merged table entry |
| phys_addr | output | 32 | Frame joined with page offset |
| fault | output | 1 | Page fault |
| fault_code | output | 3 | Fault error code |

## Verification
The first access uses fresh entries with accessed bits clear, which tells a full two-write walk apart from one that skips the bookkeeping. A write to a clean but accessed page isolates the dirty-bit write-back. Absent directory and absent table entries are tried separately; the first must stop after one read, the second after two. Repeated, aliased and post-flush accesses to the same cache slot tell a real hit from a stale or wrongly tagged one, and they show that the privilege and write-protect checks are still applied to a cached entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int PG_SH  = 12;
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int IX_W   = 10;

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_DRD, S_DWB, S_TRD, S_TWB, S_FIN
  } walk_st_e;

  function automatic logic [VA_W-1:0] merge_perm(input logic [VA_W-1:0] dent,
                                                 input logic [VA_W-1:0] tent);
    logic [VA_W-1:0] r;
    r        = tent;
    r[B_WR]  = tent[B_WR]  & dent[B_WR];
    r[B_USR] = tent[B_USR] & dent[B_USR];
    return r;
  endfunction
endpackage

// File: rtl/xlat_tcache.sv
module xlat_tcache #(
  parameter int IDX_W = 4,
  parameter int VPN_W = 20,
  parameter int ENT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [VPN_W-IDX_W-1:0] cmp_tag,
  output logic                   hit,
  output logic [ENT_W-1:0]       hit_entry,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VPN_W-IDX_W-1:0] wr_tag,
  input  logic [ENT_W-1:0]       wr_entry
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WRD_W = TAG_W + ENT_W;

  logic [WRD_W-1:0] ram [DEPTH];
  logic [WRD_W-1:0] rd_word;
  logic [DEPTH-1:0] valid;
  logic             rd_valid;

  // tag+entry storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_tag, wr_entry};
    rd_word <= ram[rd_idx];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst || flush)                      valid[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g))) valid[g] <= 1'b1;
    end
  end

  // a flush in the lookup cycle must not let a stale line through
  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= valid[rd_idx] && !flush;
  end

  assign hit       = rd_valid && (rd_word[ENT_W +: TAG_W] == cmp_tag);
  assign hit_entry = rd_word[ENT_W-1:0];
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm (
  input  logic       pres,
  input  logic       wbit,
  input  logic       ubit,
  input  logic       acc_wr,
  input  logic [1:0] priv,
  input  logic       wp_en,
  output logic       fault,
  output logic [2:0] code
);
  logic user_lvl;
  logic sup_fault;
  logic wp_fault;

  always_comb begin
    user_lvl  = (priv != 2'd0);
    sup_fault = !ubit && user_lvl;
    wp_fault  = acc_wr && wp_en && !wbit;
    fault     = !pres || sup_fault || wp_fault;
    code      = {user_lvl, acc_wr, pres};
  end
endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
  import xlat_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [VA_W-1:0]        lin_addr,
  input  logic                   is_write,
  input  logic [1:0]             priv,
  input  logic [VA_W-1:0]        dir_base,
  input  logic                   wp_en,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [VA_W-1:0]        mem_addr,
  output logic [VA_W-1:0]        mem_wdata,
  input  logic                   mem_ack,
  input  logic [VA_W-1:0]        mem_rdata,
  output logic [IDX_W-1:0]       c_rd_idx,
  output logic [VPN_W-IDX_W-1:0] c_tag,
  input  logic                   c_hit,
  input  logic [VA_W-1:0]        c_entry,
  output logic                   c_fill,
  output logic [VA_W-1:0]        c_fill_entry,
  output logic                   fin,
  output logic [VA_W-1:0]        res_entry,
  output logic [VA_W-1:0]        res_va,
  output logic                   res_wr,
  output logic [1:0]             res_priv,
  output logic                   res_wp
);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam logic [VA_W-1:0] ACC_M = VA_W'(1) << B_ACC;
  localparam logic [VA_W-1:0] DRT_M = VA_W'(1) << B_DRT;

  walk_st_e        st;
  logic [VA_W-1:0] va_q, base_q, pde_q, pte_q, res_q;
  logic            wr_q, wp_q, fill_q;
  logic [1:0]      priv_q;
  logic [IX_W-1:0] dir_ix, tbl_ix;
  logic [VA_W-1:0] pde_addr, pte_addr, pte_upd;
  logic            dir_ph;

  always_comb begin
    dir_ix   = va_q[VA_W-1 -: IX_W];
    tbl_ix   = va_q[PG_SH +: IX_W];
    pde_addr = base_q + {{(VA_W-IX_W-2){1'b0}}, dir_ix, 2'b00};
    pte_addr = {pde_q[VA_W-1:PG_SH], {PG_SH{1'b0}}}
             + {{(VA_W-IX_W-2){1'b0}}, tbl_ix, 2'b00};
    pte_upd  = mem_rdata | ACC_M | (wr_q ? DRT_M : '0);
    dir_ph   = (st == S_DRD) || (st == S_DWB);
    mem_req  = (st == S_DRD) || (st == S_DWB) || (st == S_TRD) || (st == S_TWB);
    mem_we   = (st == S_DWB) || (st == S_TWB);
    mem_addr = dir_ph ? pde_addr : pte_addr;
    mem_wdata = (st == S_DWB) ? (pde_q | ACC_M) : pte_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      fill_q <= 1'b0;
      va_q   <= '0;
      base_q <= '0;
      pde_q  <= '0;
      pte_q  <= '0;
      res_q  <= '0;
      wr_q   <= 1'b0;
      wp_q   <= 1'b0;
      priv_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          va_q   <= lin_addr;
          wr_q   <= is_write;
          priv_q <= priv;
          base_q <= dir_base;
          wp_q   <= wp_en;
          fill_q <= 1'b0;
          st     <= S_LOOK;
        end
        S_LOOK: begin
          if (c_hit) begin
            res_q <= c_entry;
            st    <= S_FIN;
          end else begin
            st <= S_DRD;
          end
        end
        S_DRD: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[B_PRES]) begin
            res_q <= '0;
            st    <= S_FIN;
          end else if (!mem_rdata[B_ACC]) begin
            st <= S_DWB;
          end else begin
            st <= S_TRD;
          end
        end
        S_DWB: if (mem_ack) st <= S_TRD;
        S_TRD: if (mem_ack) begin
          pte_q <= pte_upd;
          if (!mem_rdata[B_PRES]) begin
            res_q <= '0;
            st    <= S_FIN;
          end else if (pte_upd != mem_rdata) begin
            st <= S_TWB;
          end else begin
            res_q  <= merge_perm(pde_q, pte_upd);
            fill_q <= 1'b1;
            st     <= S_FIN;
          end
        end
        S_TWB: if (mem_ack) begin
          res_q  <= merge_perm(pde_q, pte_q);
          fill_q <= 1'b1;
          st     <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign c_rd_idx     = (st == S_IDLE) ? lin_addr[PG_SH +: IDX_W] : va_q[PG_SH +: IDX_W];
  assign c_tag        = va_q[PG_SH+IDX_W +: TAG_W];
  assign c_fill       = (st == S_FIN) && fill_q;
  assign c_fill_entry = res_q;
  assign fin          = (st == S_FIN);
  assign res_entry    = res_q;
  assign res_va       = va_q;
  assign res_wr       = wr_q;
  assign res_priv     = priv_q;
  assign res_wp       = wp_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_TBL_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
    (st == S_TRD) |-> pde_q[B_PRES]); // R2
  AST_DIR_WB_ACC: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && dir_ph) |-> (mem_wdata[B_ACC] && mem_addr == pde_addr)); // R3
  AST_TBL_WB_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (st == S_TWB && wr_q) |-> (mem_wdata[B_DRT] && mem_wdata[B_ACC])); // R4
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        start,
  input  logic [31:0] lin_addr,
  input  logic        is_write,
  input  logic [1:0]  priv,
  input  logic [31:0] dir_base,
  input  logic        wp_en,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] entry,
  output logic [31:0] phys_addr,
  output logic        fault,
  output logic [2:0]  fault_code
);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [IDX_W-1:0] c_rd_idx;
  logic [TAG_W-1:0] c_tag;
  logic             c_hit, c_fill, fin, res_wr, res_wp;
  logic [31:0]      c_entry, c_fill_entry, res_entry, res_va;
  logic [1:0]       res_priv;
  logic             p_fault;
  logic [2:0]       p_code;

  xlat_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .lin_addr(lin_addr),
    .is_write(is_write), .priv(priv), .dir_base(dir_base), .wp_en(wp_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .c_rd_idx(c_rd_idx), .c_tag(c_tag), .c_hit(c_hit), .c_entry(c_entry),
    .c_fill(c_fill), .c_fill_entry(c_fill_entry), .fin(fin),
    .res_entry(res_entry), .res_va(res_va), .res_wr(res_wr),
    .res_priv(res_priv), .res_wp(res_wp)
  );

  xlat_tcache #(.IDX_W(IDX_W), .VPN_W(VPN_W), .ENT_W(32)) u_cache (
    .clk(clk), .rst(rst), .flush(flush), .rd_idx(c_rd_idx), .cmp_tag(c_tag),
    .hit(c_hit), .hit_entry(c_entry), .wr_en(c_fill),
    .wr_idx(res_va[PG_SH +: IDX_W]), .wr_tag(c_tag), .wr_entry(c_fill_entry)
  );

  xlat_perm u_perm (
    .pres(res_entry[B_PRES]), .wbit(res_entry[B_WR]), .ubit(res_entry[B_USR]),
    .acc_wr(res_wr), .priv(res_priv), .wp_en(res_wp),
    .fault(p_fault), .code(p_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      entry      <= '0;
      phys_addr  <= '0;
    end else begin
      done  <= fin;
      fault <= fin && p_fault;
      if (fin) begin
        fault_code <= p_code;
        entry      <= res_entry;
        phys_addr  <= {res_entry[31:PG_SH], res_va[PG_SH-1:0]};
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_FAULT_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> done); // R11
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && !fault_code[0]) |-> (entry == 32'd0 && fault)); // R2
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req); // R11
endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, start = 1'b0, is_write = 1'b0, wp_en = 1'b0;
  logic [31:0] lin_addr = '0, dir_base = '0;
  logic [1:0]  priv = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done, fault;
  logic [31:0] entry, phys_addr;
  logic [2:0]  fault_code;

  always #2 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst(rst), .flush(flush), .start(start), .lin_addr(lin_addr),
    .is_write(is_write), .priv(priv), .dir_base(dir_base), .wp_en(wp_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .entry(entry), .phys_addr(phys_addr), .fault(fault),
    .fault_code(fault_code)
  );

  typedef struct packed {
    logic [31:0] ent;
    logic [31:0] pa;
    logic        flt;
    logic [2:0]  code;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [31:0] rd0;
    logic [31:0] rd1;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [4096];
  int          total = 0, bad = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr [2];
  logic        m_valid [16];
  logic [15:0] m_tag [16];
  logic [31:0] m_ent [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural memory: one acknowledged access per open request
  initial begin
    forever begin
      @(negedge clk);
      if (rst) mem_ack = 1'b0;
      else if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[13:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[13:2]];
          if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
          rd_cnt++;
        end
        mem_ack = 1'b1;
      end else mem_ack = 1'b0;
    end
  end

  // reference model of one translation, computed before the walk
  task automatic model(input logic [31:0] va, input logic wr, input logic [1:0] pv, input logic wp);
    exp_t e;
    logic [31:0] pde, pte, upd, res, a;
    int ix;
    e = '0;
    ix = int'(va[15:12]);
    if (m_valid[ix] && m_tag[ix] == va[31:16]) res = m_ent[ix];
    else begin
      a = dir_base + {20'd0, va[31:22], 2'b00};
      pde = mem[a[13:2]];
      e.nrd = 1; e.rd0 = a;
      if (!pde[0]) res = '0;
      else begin
        if (!pde[5]) e.nwr = e.nwr + 1;
        a = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
        pte = mem[a[13:2]];
        e.nrd = 2; e.rd1 = a;
        if (!pte[0]) res = '0;
        else begin
          upd = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (upd != pte) e.nwr = e.nwr + 1;
          res = upd;
          res[1] = upd[1] & pde[1];
          res[2] = upd[2] & pde[2];
          m_valid[ix] = 1'b1; m_tag[ix] = va[31:16]; m_ent[ix] = res;
        end
      end
    end
    e.ent  = res;
    e.pa   = {res[31:12], va[11:0]};
    e.code = {pv != 2'd0, wr, res[0]};
    e.flt  = !res[0] || (!res[2] && pv != 2'd0) || (wr && wp && !res[1]);
    sb.push_back(e);
  endtask

  task automatic run(input logic [31:0] va, input logic wr, input logic [1:0] pv, input logic wp);
    model(va, wr, pv, wp);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; rd_addr[0] = '0; rd_addr[1] = '0;
    lin_addr = va; is_write = wr; priv = pv; wp_en = wp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  // monitor: compare every completion with the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk("R1 R4 R5 entry", entry, e.ent);
          chk("R1 phys_addr", phys_addr, e.pa);
          chk("R8 R9 fault", {31'd0, fault}, {31'd0, e.flt});
          chk("R10 fault_code", {29'd0, fault_code}, {29'd0, e.code});
          chk("R6 R2 reads", rd_cnt, {28'd0, e.nrd});
          chk("R3 R4 writes", wr_cnt, {28'd0, e.nwr});
          if (e.nrd >= 1) chk("R1 directory address", rd_addr[0], e.rd0);
          if (e.nrd >= 2) chk("R1 table address", rd_addr[1], e.rd1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] va_of(input int d, input int t, input int off);
    return (32'(d) << 22) | (32'(t) << 12) | 32'(off);
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; m_ent[i] = '0; end
    mem[0]                = 32'h0000_1007;   // dir 0: P W U, not accessed
    mem[1]                = 32'h0000_2025;   // dir 1: P U A, read-only
    mem[3]                = 32'h0000_1023;   // dir 3: P W A, supervisor
    mem[12'h400 + 0]      = 32'h0000_5007;   // tbl1[0]: P W U, fresh
    mem[12'h400 + 1]      = 32'h0000_6067;   // tbl1[1]: A D set
    mem[12'h400 + 3]      = 32'h0000_7027;   // tbl1[3]: A set, clean
    mem[12'h800 + 0]      = 32'h0000_8067;   // tbl2[0]

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 done after reset", {31'd0, done}, 32'd0);
    chk("R12 fault after reset", {31'd0, fault}, 32'd0);
    chk("R12 mem_req after reset", {31'd0, mem_req}, 32'd0);

    run(va_of(0, 0, 12'h123), 1'b0, 2'd0, 1'b0);   // R3 R4 fresh walk, empty cache R12
    chk("R3 directory accessed bit in memory", {31'd0, mem[0][5]}, 32'd1);
    chk("R4 table accessed bit in memory", {31'd0, mem[12'h400][5]}, 32'd1);
    chk("R4 no dirty on read", {31'd0, mem[12'h400][6]}, 32'd0);
    run(va_of(0, 0, 12'h004), 1'b0, 2'd3, 1'b0);   // R6 hit
    run(va_of(0, 3, 12'hFFF), 1'b1, 2'd3, 1'b1);   // R4 dirty write-back
    chk("R4 dirty bit in memory", {31'd0, mem[12'h403][6]}, 32'd1);
    run(va_of(2, 0, 0), 1'b0, 2'd3, 1'b0);         // R2 absent directory
    run(va_of(0, 2, 0), 1'b1, 2'd0, 1'b0);         // R2 absent table
    chk("R2 absent table untouched", mem[12'h402], 32'd0);
    run(va_of(3, 0, 12'h010), 1'b0, 2'd3, 1'b0);   // R8 R5 supervisor via directory
    run(va_of(3, 0, 12'h010), 1'b0, 2'd0, 1'b0);   // R8 hit at level 0: no fault
    run(va_of(1, 0, 12'h800), 1'b1, 2'd0, 1'b1);   // R9 write-protect fault
    run(va_of(1, 0, 12'h800), 1'b1, 2'd0, 1'b0);   // R9 no wp: no fault (hit)
    @(negedge clk); flush = 1'b1;
    for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
    @(negedge clk); flush = 1'b0;
    run(va_of(1, 0, 12'h800), 1'b0, 2'd1, 1'b0);   // R7 walk after flush
    run(va_of(0, 1, 12'h0AB), 1'b0, 2'd1, 1'b0);   // R5 clean walk, no writes
    chk("R11 scoreboard drained", sb.size(), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule